// File: doc/BRIEF.md
# Packetizing Network Interface Controller

This block joins one processing unit (a master or a slave) to its router port. It is a Moore state machine that works in both directions. Toward the network, it accepts a request from the processing unit, turns the destination, the command and the payload word into a short packet of flits, and forwards that packet to the router. It then waits for the router to answer. An acknowledge ends the transaction. A negative acknowledge makes it send the whole packet again.

In the other direction, the router presents a packet that starts with a head flit. The block collects the payload flits up to the tail and unpacks them into one wide word together with the coordinates and the command from the head. It then offers the result to the processing unit and waits for the unit's handshake in the same way. Both directions pass through the same five states in the same order: idle, read, process, forward and wait-for-acknowledge. Only one transaction is in flight at a time, and when both sides ask in the same cycle the router is served first.

A slave-side unit uses the inbound path to receive a command. It answers by issuing an outbound request of its own, which carries either the data it read or nothing beyond the acknowledge of a stored write.

Top module: `pkt_ni`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tx_valid`, `pu_rx_valid`, `pu_taken` and `pu_done` are 0 and `pu_rx_data` is 0.
- R2: When `pu_req` is seen in idle, `pu_taken` is high for exactly the next cycle. `tx_valid` rises two cycles after that and stays high for `PAY_FLITS`+1 consecutive cycles.
- R3: The first flit sent has kind bits [17:16] = 2'b01 (head). Its data field carries the command in bit 0 (1 = write), the Y coordinate in bits [3:1], the X coordinate in bits [6:4], and zeros in bits [15:7].
- R4: Flit k+1 (k counted from 0) carries `pu_wdata[16k+15:16k]`. The last payload flit has kind 2'b10 (tail) and every other payload flit has kind 2'b00 (body).
- R5: After the last flit, `tx_valid` stays low until the router answers. A `tx_ack` sampled in this wait state produces a one-cycle `pu_done` in the next cycle and returns the block to idle.
- R6: A `tx_nack` sampled in the wait state restarts the transfer. The head flit is on `tx_flit` with `tx_valid` high in the very next cycle, and the whole packet is sent again unchanged.
- R7: A `tx_ack` that arrives while flits are still being sent has no effect. `pu_done` stays low and the block still waits for a later acknowledge.
- R8: A head flit (kind 2'b01) on `rx_valid` in idle starts a receive. Body and tail flits fill `pu_rx_data` from the low 16 bits upward. `pu_rx_valid` pulses for one cycle two cycles after the tail is sampled, with the head's X, Y and command on `pu_rx_x`, `pu_rx_y` and `pu_rx_cmd`.
- R9: After delivery the block waits for the unit. `pu_ack` returns it to idle. `pu_nack` re-presents the same data with `pu_rx_valid` high in the next cycle.
- R10: When a head flit and `pu_req` arrive in the same idle cycle, the inbound packet is served first and `pu_taken` stays low throughout that transaction.
- R11: A `pu_req` held during an inbound transaction is taken in the cycle after that transaction returns to idle.
- R12: Payload slots that a short inbound packet does not fill read as 0. They never keep data from an earlier packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pu_req | input | 1 | Unit requests an outbound transfer; held until `pu_taken` |
| pu_dst_x | input | 3 | Destination X coordinate |
| pu_dst_y | input | 3 | Destination Y coordinate |
| pu_cmd | input | 1 | Command, 1 = write, 0 = read |
| pu_wdata | input | 32 | Payload word, low half goes out first |
| pu_taken | output | 1 | Request accepted and fields latched |
| pu_done | output | 1 | One-cycle pulse when the router has acknowledged |
| tx_valid | output | 1 | Flit present toward the router |
| tx_flit | output | 18 | Outbound flit: kind [17:16], data [15:0] |
| tx_ack | input | 1 | Router accepted the packet |
| tx_nack | input | 1 | Router rejected the packet; resend |
| rx_valid | input | 1 | Flit present from the router |
| rx_flit | input | 18 | Inbound flit, same format as `tx_flit` |
| pu_rx_valid | output | 1 | Unpacked packet offered to the unit |
| pu_rx_x | output | 3 | X coordinate from the inbound head |
| pu_rx_y | output | 3 | Y coordinate from the inbound head |
| pu_rx_cmd | output | 1 | Command from the inbound head |
| pu_rx_data | output | 32 | Unpacked payload |
| pu_ack | input | 1 | Unit accepted the delivered packet |
| pu_nack | input | 1 | Unit refused the delivered packet; offer again |

## Verification
The assertions run on every cycle. They check that an acknowledge in the wait state leads to idle and that a negative acknowledge leads back to the first flit. They also check that `pu_done` only follows an acknowledged wait, that a request is only taken from idle, that the router wins a tie, that the head and tail kinds sit at the two ends of the outbound packet, and that the receive counter stays in range. Other behaviour needs the bench's scenarios: the exact field positions and payload order of real packets, the cycle on which each output moves, a stray acknowledge being ignored, and stale payload being cleared by a short packet. So does a request that waits out a whole inbound transaction before it is taken.

// File: rtl/pkt_ni_pkg.sv
package pkt_ni_pkg;

  localparam int FLIT_DATA_W = 16;
  localparam int COORD_W     = 3;
  localparam int KIND_W      = 2;
  localparam int FLIT_W      = FLIT_DATA_W + KIND_W;

  typedef enum logic [KIND_W-1:0] {
    FT_BODY = 2'b00,
    FT_HEAD = 2'b01,
    FT_TAIL = 2'b10
  } flit_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_PROC,
    ST_FWD,
    ST_WAIT
  } ni_state_e;

  typedef enum logic {
    DIR_OUT = 1'b0,
    DIR_IN  = 1'b1
  } ni_dir_e;

  function automatic logic [FLIT_W-1:0] make_flit(input flit_kind_e kind,
                                                  input logic [FLIT_DATA_W-1:0] data);
    return {kind, data};
  endfunction

  function automatic flit_kind_e kind_of(input logic [FLIT_W-1:0] flit);
    return flit_kind_e'(flit[FLIT_W-1 -: KIND_W]);
  endfunction

  // command in bit 0, Y above it, X above Y, rest zero
  function automatic logic [FLIT_DATA_W-1:0] head_word(input logic [COORD_W-1:0] x,
                                                       input logic [COORD_W-1:0] y,
                                                       input logic cmd);
    logic [FLIT_DATA_W-1:0] w;
    w = '0;
    w[0] = cmd;
    w[COORD_W:1] = y;
    w[2*COORD_W:COORD_W+1] = x;
    return w;
  endfunction

  function automatic logic head_cmd(input logic [FLIT_DATA_W-1:0] w);
    return w[0];
  endfunction

  function automatic logic [COORD_W-1:0] head_y(input logic [FLIT_DATA_W-1:0] w);
    return w[COORD_W:1];
  endfunction

  function automatic logic [COORD_W-1:0] head_x(input logic [FLIT_DATA_W-1:0] w);
    return w[2*COORD_W:COORD_W+1];
  endfunction

endpackage

// File: rtl/pkt_ni_ctrl.sv
module pkt_ni_ctrl
  import pkt_ni_pkg::*;
#(
  parameter int PAY_FLITS = 2,
  localparam int IDX_W = $clog2(PAY_FLITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pu_req,
  input  logic             rx_valid,
  input  flit_kind_e       rx_kind,
  input  logic             tx_ack,
  input  logic             tx_nack,
  input  logic             pu_ack,
  input  logic             pu_nack,
  output ni_state_e        state,
  output ni_dir_e          dir,
  output logic [IDX_W-1:0] fwd_idx,
  output logic             ev_start_out,
  output logic             ev_start_in,
  output logic             ev_capture,
  output logic             ev_build_out,
  output logic             ev_unpack_in,
  output logic             tx_valid,
  output logic             pu_rx_valid,
  output logic             pu_taken,
  output logic             pu_done
);

  ni_state_e        state_q, state_d;
  ni_dir_e          dir_q, dir_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q;

  logic rx_head, ev_end_rx, ev_last_flit, ev_done, ev_retry;
  logic ack_sel, nack_sel;

  assign rx_head      = rx_valid && (rx_kind == FT_HEAD);
  assign ev_start_in  = (state_q == ST_IDLE) && rx_head;
  assign ev_start_out = (state_q == ST_IDLE) && pu_req && !rx_head;
  assign ev_capture   = (state_q == ST_READ) && (dir_q == DIR_IN) && rx_valid
                        && (rx_kind != FT_HEAD);
  assign ev_end_rx    = ev_capture && (rx_kind == FT_TAIL);
  assign ev_build_out = (state_q == ST_PROC) && (dir_q == DIR_OUT);
  assign ev_unpack_in = (state_q == ST_PROC) && (dir_q == DIR_IN);
  assign ev_last_flit = (state_q == ST_FWD)
                        && ((dir_q == DIR_IN) || (idx_q == IDX_W'(PAY_FLITS)));
  assign ack_sel      = (dir_q == DIR_OUT) ? tx_ack  : pu_ack;
  assign nack_sel     = (dir_q == DIR_OUT) ? tx_nack : pu_nack;
  assign ev_done      = (state_q == ST_WAIT) && ack_sel;
  assign ev_retry     = (state_q == ST_WAIT) && !ack_sel && nack_sel;

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ev_start_in) begin
          state_d = ST_READ;
          dir_d   = DIR_IN;
        end else if (ev_start_out) begin
          state_d = ST_READ;
          dir_d   = DIR_OUT;
        end
      end
      ST_READ: begin
        if ((dir_q == DIR_OUT) || ev_end_rx) state_d = ST_PROC;
      end
      ST_PROC: begin
        state_d = ST_FWD;
        idx_d   = '0;
      end
      ST_FWD: begin
        if (ev_last_flit) state_d = ST_WAIT;
        else              idx_d   = idx_q + 1'b1;
      end
      ST_WAIT: begin
        if (ev_done) begin
          state_d = ST_IDLE;
        end else if (ev_retry) begin
          state_d = ST_FWD;
          idx_d   = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= DIR_OUT;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      idx_q   <= idx_d;
      done_q  <= ev_done && (dir_q == DIR_OUT);
    end
  end

  // Moore outputs: decoded from registered state only
  assign state       = state_q;
  assign dir         = dir_q;
  assign fwd_idx     = idx_q;
  assign tx_valid    = (state_q == ST_FWD)  && (dir_q == DIR_OUT);
  assign pu_rx_valid = (state_q == ST_FWD)  && (dir_q == DIR_IN);
  assign pu_taken    = (state_q == ST_READ) && (dir_q == DIR_OUT);
  assign pu_done     = done_q;

  a_r5_ack_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (state_q == ST_IDLE));

  a_r6_nack_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry |=> (state_q == ST_FWD && idx_q == '0));

  a_r7_done_needs_wait: assert property (@(posedge clk) disable iff (!rst_n)
    pu_done |-> $past(state_q == ST_WAIT && tx_ack));

  a_r10_router_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && rx_head && pu_req) |=> (dir_q == DIR_IN && !pu_taken));

  a_r11_taken_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pu_taken) |-> $past(state_q == ST_IDLE && pu_req));

endmodule

// File: rtl/pkt_ni_tx_path.sv
module pkt_ni_tx_path
  import pkt_ni_pkg::*;
#(
  parameter int PAY_FLITS = 2,
  localparam int IDX_W  = $clog2(PAY_FLITS + 1),
  localparam int PAY_W  = PAY_FLITS * FLIT_DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               build,
  input  logic               tx_valid,
  input  logic [IDX_W-1:0]   fwd_idx,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic               cmd,
  input  logic [PAY_W-1:0]   wdata,
  output logic [FLIT_W-1:0]  tx_flit
);

  logic [COORD_W-1:0]            req_x, req_y;
  logic                          req_cmd;
  logic [PAY_W-1:0]              req_data;
  logic [PAY_FLITS:0][FLIT_W-1:0] pkt_q;

  function automatic flit_kind_e body_kind(input int k);
    return (k == PAY_FLITS - 1) ? FT_TAIL : FT_BODY;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_x    <= '0;
      req_y    <= '0;
      req_cmd  <= 1'b0;
      req_data <= '0;
    end else if (load) begin
      req_x    <= dst_x;
      req_y    <= dst_y;
      req_cmd  <= cmd;
      req_data <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_q <= '0;
    end else if (build) begin
      pkt_q[0] <= make_flit(FT_HEAD, head_word(req_x, req_y, req_cmd));
      for (int k = 0; k < PAY_FLITS; k++) begin
        pkt_q[k+1] <= make_flit(body_kind(k), req_data[k*FLIT_DATA_W +: FLIT_DATA_W]);
      end
    end
  end

  always_comb begin
    tx_flit = '0;
    for (int s = 0; s <= PAY_FLITS; s++) begin
      if (tx_valid && fwd_idx == IDX_W'(s)) tx_flit = pkt_q[s];
    end
  end

  a_r3_head_leads: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && fwd_idx == '0) |-> (kind_of(tx_flit) == FT_HEAD));

  a_r4_tail_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && fwd_idx == IDX_W'(PAY_FLITS)) |-> (kind_of(tx_flit) == FT_TAIL));

endmodule

// File: rtl/pkt_ni_rx_path.sv
module pkt_ni_rx_path
  import pkt_ni_pkg::*;
#(
  parameter int PAY_FLITS = 2,
  localparam int CNT_W = $clog2(PAY_FLITS + 1),
  localparam int PAY_W = PAY_FLITS * FLIT_DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   head_load,
  input  logic                   capture,
  input  logic                   unpack,
  input  logic [FLIT_DATA_W-1:0] rx_data,
  output logic [COORD_W-1:0]     pu_rx_x,
  output logic [COORD_W-1:0]     pu_rx_y,
  output logic                   pu_rx_cmd,
  output logic [PAY_W-1:0]       pu_rx_data
);

  logic [FLIT_DATA_W-1:0]                 head_q;
  logic [PAY_FLITS-1:0][FLIT_DATA_W-1:0]  slot_q;
  logic [CNT_W-1:0]                       cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      slot_q <= '0;
      cnt_q  <= '0;
    end else if (head_load) begin
      head_q <= rx_data;
      slot_q <= '0;
      cnt_q  <= '0;
    end else if (capture && cnt_q < CNT_W'(PAY_FLITS)) begin
      for (int s = 0; s < PAY_FLITS; s++) begin
        if (cnt_q == CNT_W'(s)) slot_q[s] <= rx_data;
      end
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pu_rx_x    <= '0;
      pu_rx_y    <= '0;
      pu_rx_cmd  <= 1'b0;
      pu_rx_data <= '0;
    end else if (unpack) begin
      pu_rx_x    <= head_x(head_q);
      pu_rx_y    <= head_y(head_q);
      pu_rx_cmd  <= head_cmd(head_q);
      pu_rx_data <= slot_q;
    end
  end

  a_r12_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(PAY_FLITS));

  a_r12_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
    head_load |=> (cnt_q == '0 && slot_q == '0));

endmodule

// File: rtl/pkt_ni.sv
module pkt_ni
  import pkt_ni_pkg::*;
#(
  parameter int PAY_FLITS = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               pu_req,
  input  logic [pkt_ni_pkg::COORD_W-1:0]     pu_dst_x,
  input  logic [pkt_ni_pkg::COORD_W-1:0]     pu_dst_y,
  input  logic                               pu_cmd,
  input  logic [PAY_FLITS*pkt_ni_pkg::FLIT_DATA_W-1:0] pu_wdata,
  output logic                               pu_taken,
  output logic                               pu_done,
  output logic                               tx_valid,
  output logic [pkt_ni_pkg::FLIT_W-1:0]      tx_flit,
  input  logic                               tx_ack,
  input  logic                               tx_nack,
  input  logic                               rx_valid,
  input  logic [pkt_ni_pkg::FLIT_W-1:0]      rx_flit,
  output logic                               pu_rx_valid,
  output logic [pkt_ni_pkg::COORD_W-1:0]     pu_rx_x,
  output logic [pkt_ni_pkg::COORD_W-1:0]     pu_rx_y,
  output logic                               pu_rx_cmd,
  output logic [PAY_FLITS*pkt_ni_pkg::FLIT_DATA_W-1:0] pu_rx_data,
  input  logic                               pu_ack,
  input  logic                               pu_nack
);

  localparam int IDX_W = $clog2(PAY_FLITS + 1);

  ni_state_e        state;
  ni_dir_e          dir;
  logic [IDX_W-1:0] fwd_idx;
  logic             ev_start_out, ev_start_in, ev_capture, ev_build_out, ev_unpack_in;
  flit_kind_e       rx_kind;

  assign rx_kind = kind_of(rx_flit);

  pkt_ni_ctrl #(.PAY_FLITS(PAY_FLITS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .pu_req       (pu_req),
    .rx_valid     (rx_valid),
    .rx_kind      (rx_kind),
    .tx_ack       (tx_ack),
    .tx_nack      (tx_nack),
    .pu_ack       (pu_ack),
    .pu_nack      (pu_nack),
    .state        (state),
    .dir          (dir),
    .fwd_idx      (fwd_idx),
    .ev_start_out (ev_start_out),
    .ev_start_in  (ev_start_in),
    .ev_capture   (ev_capture),
    .ev_build_out (ev_build_out),
    .ev_unpack_in (ev_unpack_in),
    .tx_valid     (tx_valid),
    .pu_rx_valid  (pu_rx_valid),
    .pu_taken     (pu_taken),
    .pu_done      (pu_done)
  );

  pkt_ni_tx_path #(.PAY_FLITS(PAY_FLITS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_start_out),
    .build    (ev_build_out),
    .tx_valid (tx_valid),
    .fwd_idx  (fwd_idx),
    .dst_x    (pu_dst_x),
    .dst_y    (pu_dst_y),
    .cmd      (pu_cmd),
    .wdata    (pu_wdata),
    .tx_flit  (tx_flit)
  );

  pkt_ni_rx_path #(.PAY_FLITS(PAY_FLITS)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_load  (ev_start_in),
    .capture    (ev_capture),
    .unpack     (ev_unpack_in),
    .rx_data    (rx_flit[FLIT_DATA_W-1:0]),
    .pu_rx_x    (pu_rx_x),
    .pu_rx_y    (pu_rx_y),
    .pu_rx_cmd  (pu_rx_cmd),
    .pu_rx_data (pu_rx_data)
  );

  a_r2_one_side_active: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && pu_rx_valid));

  a_r8_deliver_after_proc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pu_rx_valid) |-> $past(state == ST_PROC || state == ST_WAIT));

  a_r9_wait_holds_in: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && dir == DIR_IN && !pu_ack && !pu_nack) |=> (state == ST_WAIT));

endmodule

// File: tb/pkt_ni_bench.sv
`timescale 1ns/1ps
module pkt_ni_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pu_req = 1'b0;
  logic [2:0]  pu_dst_x = '0, pu_dst_y = '0;
  logic        pu_cmd = 1'b0;
  logic [31:0] pu_wdata = '0;
  logic        pu_taken, pu_done, tx_valid;
  logic [17:0] tx_flit;
  logic        tx_ack = 1'b0, tx_nack = 1'b0;
  logic        rx_valid = 1'b0;
  logic [17:0] rx_flit = '0;
  logic        pu_rx_valid;
  logic [2:0]  pu_rx_x, pu_rx_y;
  logic        pu_rx_cmd;
  logic [31:0] pu_rx_data;
  logic        pu_ack = 1'b0, pu_nack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  pkt_ni u_pkt_ni (
    .clk(clk), .rst_n(rst_n), .pu_req(pu_req), .pu_dst_x(pu_dst_x), .pu_dst_y(pu_dst_y),
    .pu_cmd(pu_cmd), .pu_wdata(pu_wdata), .pu_taken(pu_taken), .pu_done(pu_done),
    .tx_valid(tx_valid), .tx_flit(tx_flit), .tx_ack(tx_ack), .tx_nack(tx_nack),
    .rx_valid(rx_valid), .rx_flit(rx_flit), .pu_rx_valid(pu_rx_valid), .pu_rx_x(pu_rx_x),
    .pu_rx_y(pu_rx_y), .pu_rx_cmd(pu_rx_cmd), .pu_rx_data(pu_rx_data),
    .pu_ack(pu_ack), .pu_nack(pu_nack)
  );

  // x, y, cmd, payload
  localparam logic [38:0] OUT_VEC [4] = '{
    {3'd1, 3'd2, 1'b1, 32'hDEAD_BEEF},
    {3'd7, 3'd0, 1'b0, 32'h0000_0001},
    {3'd0, 3'd7, 1'b1, 32'hFFFF_0000},
    {3'd5, 3'd5, 1'b0, 32'h1234_5678}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [17:0] exp_head(input logic [2:0] x, input logic [2:0] y, input logic c);
    int v;
    v = x * 16 + y * 2 + (c ? 1 : 0);
    return {2'b01, 16'(v)};
  endfunction

  // walk the flits of one packet; the first is already on the port
  task automatic collect(input logic [17:0] e0, input logic [31:0] wd, input bit stray_ack);
    logic [17:0] exp;
    for (int i = 0; i < 3; i++) begin
      if (i == 0) exp = e0;
      else exp = {(i == 2) ? 2'b10 : 2'b00, wd[16*(i-1) +: 16]};
      chk(tx_valid == 1'b1, "R2 flit valid run", 64'(tx_valid), 64'd1);
      chk(tx_flit == exp, (i == 0) ? "R3 head flit" : "R4 payload flit", 64'(tx_flit), 64'(exp));
      if (stray_ack) tx_ack = (i == 0);
      @(negedge clk);
    end
    tx_ack = 1'b0;
  endtask

  // mode 0: ack, 1: nack then ack, 2: stray ack during flits then ack
  task automatic run_out(input logic [2:0] x, input logic [2:0] y, input logic c,
                         input logic [31:0] wd, input int mode);
    logic [17:0] h;
    h = exp_head(x, y, c);
    pu_dst_x = x; pu_dst_y = y; pu_cmd = c; pu_wdata = wd; pu_req = 1'b1;
    @(negedge clk);
    chk(pu_taken == 1'b1, "R2 taken next cycle", 64'(pu_taken), 64'd1);
    pu_req = 1'b0;
    @(negedge clk);
    chk(pu_taken == 1'b0, "R2 taken one cycle", 64'(pu_taken), 64'd0);
    chk(tx_valid == 1'b0, "R2 no flit while processing", 64'(tx_valid), 64'd0);
    @(negedge clk);
    collect(h, wd, mode == 2);
    chk(tx_valid == 1'b0, "R5 quiet in wait", 64'(tx_valid), 64'd0);
    chk(pu_done == 1'b0, "R7 no done before wait ack", 64'(pu_done), 64'd0);
    if (mode == 1) begin
      tx_nack = 1'b1;
      @(negedge clk);
      tx_nack = 1'b0;
      chk(pu_done == 1'b0, "R6 no done on nack", 64'(pu_done), 64'd0);
      collect(h, wd, 1'b0);
      chk(tx_valid == 1'b0, "R6 quiet after resend", 64'(tx_valid), 64'd0);
    end
    tx_ack = 1'b1;
    @(negedge clk);
    tx_ack = 1'b0;
    chk(pu_done == 1'b1, "R5 done pulse", 64'(pu_done), 64'd1);
    @(negedge clk);
    chk(pu_done == 1'b0, "R5 done single cycle", 64'(pu_done), 64'd0);
    chk(tx_valid == 1'b0, "R5 idle after ack", 64'(tx_valid), 64'd0);
  endtask

  // inbound packet with nw payload flits (1 or 2)
  task automatic send_in(input logic [2:0] x, input logic [2:0] y, input logic c,
                         input logic [31:0] wd, input int nw, input bit nack_first,
                         input bit hold_check);
    logic [31:0] exp_data;
    exp_data = (nw == 1) ? {16'h0, wd[15:0]} : wd;
    rx_valid = 1'b1;
    rx_flit  = exp_head(x, y, c);
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      if (hold_check) chk(pu_taken == 1'b0, "R10 request held back", 64'(pu_taken), 64'd0);
      rx_flit = {(w == nw - 1) ? 2'b10 : 2'b00, wd[16*w +: 16]};
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_flit  = '0;
    chk(pu_rx_valid == 1'b0, "R8 not yet delivered", 64'(pu_rx_valid), 64'd0);
    if (hold_check) chk(pu_taken == 1'b0, "R10 request held back", 64'(pu_taken), 64'd0);
    @(negedge clk);
    chk(pu_rx_valid == 1'b1, "R8 delivery pulse", 64'(pu_rx_valid), 64'd1);
    chk(pu_rx_data == exp_data, (nw == 1) ? "R12 short packet data" : "R8 unpacked data",
        64'(pu_rx_data), 64'(exp_data));
    chk({pu_rx_x, pu_rx_y, pu_rx_cmd} == {x, y, c}, "R8 head fields",
        64'({pu_rx_x, pu_rx_y, pu_rx_cmd}), 64'({x, y, c}));
    @(negedge clk);
    chk(pu_rx_valid == 1'b0, "R8 single pulse", 64'(pu_rx_valid), 64'd0);
    if (nack_first) begin
      pu_nack = 1'b1;
      @(negedge clk);
      pu_nack = 1'b0;
      chk(pu_rx_valid == 1'b1, "R9 re-offer after nack", 64'(pu_rx_valid), 64'd1);
      chk(pu_rx_data == exp_data, "R9 same data", 64'(pu_rx_data), 64'(exp_data));
      @(negedge clk);
    end
    if (hold_check) chk(pu_taken == 1'b0, "R11 not taken before ack", 64'(pu_taken), 64'd0);
    pu_ack = 1'b1;
    @(negedge clk);
    pu_ack = 1'b0;
    chk(pu_rx_valid == 1'b0, "R9 idle after ack", 64'(pu_rx_valid), 64'd0);
    if (hold_check) chk(pu_taken == 1'b0, "R11 taken after idle", 64'(pu_taken), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({tx_valid, pu_rx_valid, pu_taken, pu_done} == 4'b0, "R1 outputs in reset",
        64'({tx_valid, pu_rx_valid, pu_taken, pu_done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({tx_valid, pu_rx_valid, pu_taken, pu_done} == 4'b0, "R1 outputs after reset",
        64'({tx_valid, pu_rx_valid, pu_taken, pu_done}), 64'd0);
    chk(pu_rx_data == 32'h0, "R1 rx data cleared", 64'(pu_rx_data), 64'd0);

    for (int v = 0; v < 4; v++) begin
      run_out(OUT_VEC[v][38:36], OUT_VEC[v][35:33], OUT_VEC[v][32], OUT_VEC[v][31:0], 0);
    end

    run_out(3'd3, 3'd4, 1'b1, 32'hA5A5_5A5A, 1);   // R6
    run_out(3'd6, 3'd1, 1'b0, 32'hC001_D00D, 2);   // R7

    send_in(3'd2, 3'd3, 1'b1, 32'hCAFE_F00D, 2, 1'b0, 1'b0);  // R8
    send_in(3'd4, 3'd6, 1'b0, 32'h0BAD_1DEA, 2, 1'b1, 1'b0);  // R9
    send_in(3'd1, 3'd1, 1'b1, 32'h7777_2468, 1, 1'b0, 1'b0);  // R12

    // R10, R11: both sides ask in the same cycle
    pu_dst_x = 3'd7; pu_dst_y = 3'd7; pu_cmd = 1'b1; pu_wdata = 32'h0F0F_F0F0; pu_req = 1'b1;
    send_in(3'd5, 3'd2, 1'b0, 32'h1357_9BDF, 2, 1'b0, 1'b1);
    run_out(3'd7, 3'd7, 1'b1, 32'h0F0F_F0F0, 0);

    finish_sim();
  end

endmodule